// File: doc/BRIEF.md
# Complementary Dead-Band Generator

This block turns each of three PWM reference signals into a pair of outputs: a true output and a complementary output. It holds back the rising edge of each output so that the two can never be high at the same time. The delay after a rising reference edge and the delay after a falling reference edge are set separately, each as a 12-bit count of system clock cycles. All three channels share one 32-bit delay configuration word. Each channel has its own enable bit, so any channel can be switched to a plain bypass.

The block sits between the compare logic that creates the references and any override stage that follows it. Falling edges pass through in the same cycle. Rising edges wait until the reference has held its new level for the programmed number of clock edges. Each channel's delay timer runs at all times, whatever its enable bit says. Switching a channel's enable therefore takes effect at once and keeps the time that has already passed.

Top module: `dbgen_trio`

## Requirements
- R1: The rise delay is read from bits [11:0] of `dly_cfg` and the fall delay from bits [27:16]. All channels use the same two delays. Bit i of `db_en` enables dead band on channel i.
- R2: With its enable bit low, a channel drives `out_hi` equal to its reference and `out_lo` equal to the inverse of the reference, in the same cycle and with no delay.
- R3: With the channel enabled, the reference driven high between clock edges, and the rise delay equal to D, `out_hi` goes high right after the D-th following rising clock edge. With D = 0 it goes high in the same cycle as the reference.
- R4: With the channel enabled, the reference driven low, and the fall delay equal to D, `out_lo` goes high right after the D-th following clock edge. With D = 0 it goes high in the same cycle.
- R5: When the reference rises, `out_lo` goes low in the same cycle. When the reference falls, `out_hi` goes low in the same cycle.
- R6: If the reference changes again before a delay has run out, the pending rise is dropped. The output for the new level waits a full new delay, counted from the latest change.
- R7: `out_hi` and `out_lo` of a channel are never both high, under any inputs.
- R8: The delay timer of a channel counts whatever its enable bit is. Setting the enable makes the channel apply the delay at once, based on the time since the last reference change.
- R9: After reset, a channel that is enabled and has its reference held low drives `out_lo` high and `out_hi` low.
- R10: The largest rise delay, 4095, holds `out_hi` low for exactly 4095 clock edges after the reference rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; counts the delays |
| rst_n | input | 1 | Synchronous active-low reset |
| dly_cfg | input | 32 | Delay word: rise delay [11:0], fall delay [27:16] |
| db_en | input | 3 | Per-channel dead-band enable |
| pwm_ref | input | 3 | PWM reference for each channel |
| out_hi | output | 3 | Delayed true output for each channel |
| out_lo | output | 3 | Delayed complementary output for each channel |

## Verification
Random reference toggling at slow rates with small delays exercises the plain rise and fall delays on both edges, including delays of 0 and 1. Fast toggling produces pulses shorter than the delay, which shows whether a pending rise is correctly dropped and restarted. Random enable flips in the middle of a segment check that the timer keeps running during bypass. A directed run at the 4095 maximum exposes truncated or off-by-one counters. The three channels have different toggle rates and enables, so crossed or shared channel state also shows up as a mismatch.

// File: rtl/dbgen_pkg.sv
// Package: shared widths and field positions of the dead-band delay word.
// Assumes the delay word is 32 bits with both delay fields 12 bits wide.
package dbgen_pkg;
    localparam int DLY_W    = 12;
    localparam int CFG_W    = 32;
    localparam int RISE_LSB = 0;
    localparam int FALL_LSB = 16;

    typedef logic [DLY_W-1:0] dly_t;

    // Pull the rise-edge delay field out of the configuration word.
    function automatic dly_t rise_field(input logic [CFG_W-1:0] w);
        return w[RISE_LSB +: DLY_W];
    endfunction

    // Pull the fall-edge delay field out of the configuration word.
    function automatic dly_t fall_field(input logic [CFG_W-1:0] w);
        return w[FALL_LSB +: DLY_W];
    endfunction
endpackage

// File: rtl/dbgen_timer.sv
// Module: per-channel edge timer. It records the last reference level it
// has seen and counts down the delay that belongs to that level.
// `settled` is high when the current reference level has lasted its full
// delay. A delay of zero counts as settled in the same cycle.
// Assumes the delays stay fixed while a count is running.
module dbgen_timer #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ref_i,
    input  logic [DW-1:0] rise_dly,
    input  logic [DW-1:0] fall_dly,
    output logic          settled
);
    localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

    logic          lvl_q;
    logic [DW-1:0] cnt_q;
    logic [DW-1:0] load_val;
    logic          changed;

    // Choose the count for the new level: delay minus one, or zero.
    always_comb begin
        load_val = ref_i ? rise_dly : fall_dly;
        if (load_val != '0) load_val = load_val - ONE;
    end

    assign changed = (ref_i != lvl_q);

    // Track the level; reload on every change, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            cnt_q <= '0;
        end else if (changed) begin
            lvl_q <= ref_i;
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    // Settled: unchanged level with expired count, or new level with zero delay.
    always_comb begin
        if (!changed) settled = (cnt_q == '0);
        else          settled = ref_i ? (rise_dly == '0) : (fall_dly == '0);
    end

    // A counter left running from an older level must be reloaded on change.
    AST_CNT_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(changed) |-> (lvl_q == $past(ref_i)))
        else $error("level not captured on change"); // R6
endmodule

// File: rtl/dbgen_chan.sv
// Module: one dead-band channel. It gates the true and complementary
// outputs with the timer's settled flag. With the channel disabled it
// passes the reference and its inverse straight through.
// Assumes the reference is synchronous to clk.
module dbgen_chan #(
    parameter int DW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          ref_i,
    input  logic [DW-1:0] rise_dly,
    input  logic [DW-1:0] fall_dly,
    output logic          hi_o,
    output logic          lo_o
);
    logic settled;

    dbgen_timer #(.DW(DW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_i    (ref_i),
        .rise_dly (rise_dly),
        .fall_dly (fall_dly),
        .settled  (settled)
    );

    // Output gating: bypass when disabled, delayed rise when enabled.
    always_comb begin
        if (en) begin
            hi_o = ref_i & settled;
            lo_o = ~ref_i & settled;
        end else begin
            hi_o = ref_i;
            lo_o = ~ref_i;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(hi_o && lo_o)) else $error("both outputs high"); // R7
    AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (hi_o == ref_i) && (lo_o == !ref_i)) else $error("bypass broken"); // R2
    AST_RISE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && ref_i && !$past(ref_i) && rise_dly != '0) |-> !hi_o)
        else $error("true output rose early"); // R3
    AST_FALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !ref_i && $past(ref_i) && fall_dly != '0) |-> !lo_o)
        else $error("complement rose early"); // R4
    AST_EDGE_CUT: assert property (@(posedge clk) disable iff (!rst_n)
        en |-> (!ref_i -> !hi_o) && (ref_i -> !lo_o))
        else $error("output not cut on edge"); // R5
endmodule

// File: rtl/dbgen_trio.sv
// Module: top of the dead-band stage. It unpacks the shared delay word
// and builds one channel per reference, each with its own enable bit.
// Assumes dly_cfg is held steady while any delay count is running.
module dbgen_trio #(
    parameter int NCH = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [dbgen_pkg::CFG_W-1:0] dly_cfg,
    input  logic [NCH-1:0]             db_en,
    input  logic [NCH-1:0]             pwm_ref,
    output logic [NCH-1:0]             out_hi,
    output logic [NCH-1:0]             out_lo
);
    import dbgen_pkg::*;

    dly_t rise_dly;
    dly_t fall_dly;
    logic unused_cfg_bits;

    // Field unpack of the shared delay word.
    assign rise_dly = rise_field(dly_cfg);
    assign fall_dly = fall_field(dly_cfg);
    assign unused_cfg_bits = ^{dly_cfg[FALL_LSB-1:RISE_LSB+DLY_W],
                               dly_cfg[CFG_W-1:FALL_LSB+DLY_W]};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        dbgen_chan #(.DW(DLY_W)) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (db_en[i]),
            .ref_i    (pwm_ref[i]),
            .rise_dly (rise_dly),
            .fall_dly (fall_dly),
            .hi_o     (out_hi[i]),
            .lo_o     (out_lo[i])
        );
    end

    AST_PAIR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hi & out_lo) == '0) else $error("pair overlap at top"); // R7
endmodule

// File: tb/dbgen_trio_tb.sv
`timescale 1ns/1ps
module dbgen_trio_tb;
    localparam int NCH = 3;
    localparam int SAT = 5000;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [31:0]     dly_cfg = '0;
    logic [NCH-1:0]  db_en = '0;
    logic [NCH-1:0]  pwm_ref = '0;
    logic [NCH-1:0]  out_hi;
    logic [NCH-1:0]  out_lo;

    int vectors = 0;
    int miscompares = 0;
    int age [NCH];
    logic [NCH-1:0] prev_ref = '0;
    int cur_rise = 0;
    int cur_fall = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    dbgen_trio #(.NCH(NCH)) u_dut (
        .clk(clk), .rst_n(rst_n), .dly_cfg(dly_cfg), .db_en(db_en),
        .pwm_ref(pwm_ref), .out_hi(out_hi), .out_lo(out_lo)
    );

    // R1: pack the rise delay at [11:0] and the fall delay at [27:16].
    function automatic logic [31:0] pack_cfg(input int r, input int f);
        logic [31:0] w = '0;
        w[11:0]  = r[11:0];
        w[27:16] = f[11:0];
        return w;
    endfunction

    // Expected true output from elapsed edges since the last reference change.
    function automatic bit exp_hi(input bit en, input bit r, input int a, input int d);
        return en ? (r && a >= d) : r;
    endfunction

    function automatic bit exp_lo(input bit en, input bit r, input int a, input int d);
        return en ? (!r && a >= d) : !r;
    endfunction

    // One cycle: drive after the falling edge, update the model, sample before the rising edge.
    task automatic step(input logic [NCH-1:0] r, input logic [NCH-1:0] e, input string tag);
        @(negedge clk);
        pwm_ref = r;
        db_en = e;
        for (int i = 0; i < NCH; i++) begin
            if (r[i] != prev_ref[i]) age[i] = 0;
            else if (age[i] < SAT) age[i] = age[i] + 1;
        end
        prev_ref = r;
        #1.5;
        for (int i = 0; i < NCH; i++) begin
            bit eh = exp_hi(e[i], r[i], age[i], cur_rise);
            bit el = exp_lo(e[i], r[i], age[i], cur_fall);
            vectors++;
            if (out_hi[i] !== eh || out_lo[i] !== el) begin
                miscompares++;
                $display("FAIL %s ch%0d: hi/lo actual %b%b expected %b%b (age %0d)",
                         tag, i, out_hi[i], out_lo[i], eh, el, age[i]);
            end
        end
    endtask

    // Change delays only after the references have been steady long enough.
    task automatic set_delays(input int r, input int f);
        for (int k = 0; k < 20; k++) step(pwm_ref, db_en, "R1 settle");
        @(negedge clk);
        dly_cfg = pack_cfg(r, f);
        cur_rise = r;
        cur_fall = f;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NCH; i++) age[i] = SAT;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: enabled, reference low after reset -> complement high, true low.
        step(3'b000, 3'b111, "R9 reset state");

        // R3 R4 R5: directed edges with small delays, zero-delay cases included.
        set_delays(3, 5);
        step(3'b111, 3'b111, "R5 rise cuts complement");
        for (int k = 0; k < 8; k++) step(3'b111, 3'b111, "R3 rise delay");
        step(3'b000, 3'b111, "R5 fall cuts true");
        for (int k = 0; k < 8; k++) step(3'b000, 3'b111, "R4 fall delay");
        set_delays(0, 0);
        for (int k = 0; k < 6; k++) step(3'(k), 3'b111, "R3 R4 zero delay");
        set_delays(1, 1);
        for (int k = 0; k < 6; k++) step(3'(k), 3'b111, "R3 R4 unit delay");

        // R6: pulse shorter than the delay is dropped and retimed.
        set_delays(6, 6);
        step(3'b111, 3'b111, "R6 short pulse");
        step(3'b111, 3'b111, "R6 short pulse");
        step(3'b000, 3'b111, "R6 retrigger");
        for (int k = 0; k < 9; k++) step(3'b000, 3'b111, "R6 retimed fall");

        // R2: bypass with large delays shows no delay at all.
        set_delays(9, 9);
        for (int k = 0; k < 8; k++) step(3'(k * 5), 3'b000, "R2 bypass");

        // R8: timer counts while disabled; enabling mid-count applies at once.
        step(3'b111, 3'b000, "R8 disabled rise");
        for (int k = 0; k < 4; k++) step(3'b111, 3'b000, "R8 disabled count");
        for (int k = 0; k < 7; k++) step(3'b111, 3'b111, "R8 enabled late");

        // Random segments: R3 R4 R6 R7 R8 under varied toggle rates and enables.
        for (int seg = 0; seg < 40; seg++) begin
            int rate = 1 + ($urandom % 6);
            logic [NCH-1:0] en_v = 3'($urandom);
            set_delays($urandom % 8, $urandom % 8);
            for (int k = 0; k < 250; k++) begin
                logic [NCH-1:0] r = pwm_ref;
                for (int i = 0; i < NCH; i++)
                    if (($urandom % (rate * (i + 1))) == 0) r[i] = ~r[i];
                if (($urandom % 64) == 0) en_v = 3'($urandom);
                step(r, en_v, "R3 R4 R6 R7 R8 random");
            end
        end

        // R10: maximum rise delay.
        set_delays(4095, 3);
        step(3'b000, 3'b111, "R10 pre");
        for (int k = 0; k < 4100; k++) step(3'b111, 3'b111, "R10 max delay");
        for (int k = 0; k < 8; k++) step(3'b000, 3'b111, "R10 fall after max");

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    // Watchdog: a hung run ends as a failure but still prints the summary.
    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1;
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end
endmodule